// File: doc/BRIEF.md
# Processor Low-Power Mode Sequencer

This block steps a processor core into and out of its low-power modes. A mode request names one of four modes: RUN, IDLE, DROWSY or SLEEP. The block moves the core there and holds `ready` low until the move is complete. It drives two enables. `core_clk_en` lets the core clock through its gate. `clkgen_en` keeps the clock generator running. In IDLE only the core clock is gated. In DROWSY and SLEEP the clock generator is stopped as well.

Each move is timed by an internal counter. Its length is a parameter for each class of mode: `LAT_IDLE`, 180 cycles by default, for IDLE, and `LAT_DEEP`, 36000 by default, for DROWSY and SLEEP. Leaving a mode takes as long as entering it. A wake event brings the core back to RUN. A wake seen while the block is still entering a low-power mode is held, and the return starts as soon as the entry finishes.

The request port has a valid signal and no back-pressure. A request is looked at only in a cycle where `ready` is high. A request that is not accepted in that cycle is dropped and must be sent again. The block never chooses a mode by itself.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset, `cur_mode` is RUN (00), `ready` is 1, `core_clk_en` and `clkgen_en` are both 1, and `pwr_lvl` is 3.
- R2: Modes are encoded as 00 RUN, 01 IDLE, 10 DROWSY and 11 SLEEP. When `ready` is high:
  - in RUN, both enables are 1;
  - in IDLE, `core_clk_en` is 0 and `clkgen_en` is 1;
  - in DROWSY and in SLEEP, both enables are 0.
- R3: While in RUN with `ready` high, a request for a low-power mode is accepted.
  - `ready` then stays low for exactly `LAT_IDLE` cycles (target IDLE) or `LAT_DEEP` cycles (target DROWSY or SLEEP).
  - After that, `cur_mode` shows the target and `ready` returns to 1.
- R4: During an entry, `cur_mode` still reads RUN and both enables stay 1.
- R5: With `ready` high in a low-power mode, either `wake` or a RUN request starts the exit.
  - `clkgen_en` goes to 1 from the next cycle.
  - `core_clk_en` stays 0 while `ready` is low.
  - `ready` stays low for the latency of the mode being left.
  - The block then settles in RUN.
- R6: A `wake` seen in any cycle of an entry is held. The exit then follows the entry with no cycle of `ready` high. `ready` stays low for twice the latency, and during the exit `cur_mode` shows the low-power mode being left.
- R7: A request that arrives while `ready` is low is ignored.
- R8: The following have no effect and leave `ready` high:
  - a request for the mode already held;
  - a request from one low-power mode to another;
  - `wake` while in RUN.
- R9: `pwr_lvl` reports the nominal power class of `cur_mode`: 3 for RUN (about 450 mW), 2 for IDLE (about 10 mW), 1 for DROWSY (about 1 mW) and 0 for SLEEP (about 0 mW).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A mode request is present |
| req_mode | input | 2 | Requested mode (00 RUN, 01 IDLE, 10 DROWSY, 11 SLEEP) |
| wake | input | 1 | Wake event, returns the core to RUN |
| core_clk_en | output | 1 | Enable for the core clock gate |
| clkgen_en | output | 1 | Enable for the clock generator |
| ready | output | 1 | High when no move is in progress |
| cur_mode | output | 2 | Mode currently held |
| pwr_lvl | output | 2 | Nominal power class of `cur_mode` |

## Verification
The bench measures the exact number of cycles `ready` stays low for each kind of move.
- A counter that is off by one, or that picks the wrong latency class, would give a low run one cycle too long or too short, or of the wrong length.
- A wake during entry that is not held would let `ready` rise between entry and exit, or leave the core asleep.

The bench also sends requests in the middle of a move, requests between two low-power modes, and a wake while in RUN.
- A block that accepted any of these would change `cur_mode` or pull `ready` low.

The enables are checked at every point where a move ends and at the start of an exit.
- A wrong mode-to-enable mapping, or a clock generator restarted too late, would show there.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'b00,
    PM_IDLE   = 2'b01,
    PM_DROWSY = 2'b10,
    PM_SLEEP  = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    SQ_STEADY = 2'b00,
    SQ_ENTER  = 2'b01,
    SQ_EXIT   = 2'b10
  } sq_e;
endpackage

// File: rtl/pwrseq_timer.sv
// Down counter: load sets it, then it falls to zero and waits there.
module pwrseq_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_latsel.sv
// Picks the reload value (latency - 1) for the mode being moved to or left.
module pwrseq_latsel
  import pwrseq_pkg::*;
#(
  parameter int LAT_IDLE = 180,
  parameter int LAT_DEEP = 36000,
  parameter int CW       = 16
) (
  input  pmode_e        mode,
  output logic [CW-1:0] reload
);
  localparam logic [CW-1:0] RL_IDLE = CW'(LAT_IDLE - 1);
  localparam logic [CW-1:0] RL_DEEP = CW'(LAT_DEEP - 1);

  always_comb begin
    unique case (mode)
      PM_IDLE:            reload = RL_IDLE;
      PM_DROWSY, PM_SLEEP: reload = RL_DEEP;
      default:            reload = '0;
    endcase
  end
endmodule

// File: rtl/pwrseq_clkdec.sv
// Maps sequencer state and held mode onto clock enables and power class.
module pwrseq_clkdec
  import pwrseq_pkg::*;
(
  input  sq_e        state,
  input  pmode_e     mode,
  output logic       core_clk_en,
  output logic       clkgen_en,
  output logic [1:0] pwr_lvl
);
  always_comb begin
    core_clk_en = 1'b0;
    clkgen_en   = 1'b0;
    unique case (state)
      SQ_ENTER: begin
        core_clk_en = 1'b1;
        clkgen_en   = 1'b1;
      end
      SQ_EXIT: begin
        core_clk_en = 1'b0;
        clkgen_en   = 1'b1;
      end
      default: begin
        core_clk_en = (mode == PM_RUN);
        clkgen_en   = (mode == PM_RUN) || (mode == PM_IDLE);
      end
    endcase
  end

  // The power class is the mode code inverted: 00->3, 01->2, 10->1, 11->0.
  assign pwr_lvl = ~mode;
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pwrseq_pkg::*;
#(
  parameter int LAT_IDLE = 180,
  parameter int LAT_DEEP = 36000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake,
  output logic       core_clk_en,
  output logic       clkgen_en,
  output logic       ready,
  output logic [1:0] cur_mode,
  output logic [1:0] pwr_lvl
);
  localparam int LAT_MAX = (LAT_IDLE > LAT_DEEP) ? LAT_IDLE : LAT_DEEP;
  localparam int CW      = $clog2(LAT_MAX + 1);

  sq_e    state_q;
  pmode_e mode_q, target_q, lat_mode;
  logic   wake_pend_q;
  logic   expire, load;
  logic   accept_enter, start_exit, wake_now;
  logic [CW-1:0] reload;

  pmode_e req_m;
  assign req_m = pmode_e'(req_mode);

  assign accept_enter = (state_q == SQ_STEADY) && req_valid &&
                        (mode_q == PM_RUN) && (req_m != PM_RUN);
  assign start_exit   = (state_q == SQ_STEADY) && (mode_q != PM_RUN) &&
                        (wake || (req_valid && req_m == PM_RUN));
  assign wake_now     = wake_pend_q || wake;
  assign load         = accept_enter || start_exit ||
                        ((state_q == SQ_ENTER) && expire && wake_now);
  assign lat_mode     = accept_enter ? req_m : target_q;

  pwrseq_latsel #(.LAT_IDLE(LAT_IDLE), .LAT_DEEP(LAT_DEEP), .CW(CW)) u_latsel (
    .mode   (lat_mode),
    .reload (reload)
  );

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (reload),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_STEADY;
      mode_q      <= PM_RUN;
      target_q    <= PM_RUN;
      wake_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_STEADY: begin
          if (accept_enter) begin
            state_q  <= SQ_ENTER;
            target_q <= req_m;
          end else if (start_exit) begin
            state_q <= SQ_EXIT;
          end
        end
        SQ_ENTER: begin
          if (expire) begin
            mode_q      <= target_q;
            wake_pend_q <= 1'b0;
            state_q     <= wake_now ? SQ_EXIT : SQ_STEADY;
          end else if (wake) begin
            wake_pend_q <= 1'b1;
          end
        end
        SQ_EXIT: begin
          if (expire) begin
            mode_q   <= PM_RUN;
            target_q <= PM_RUN;
            state_q  <= SQ_STEADY;
          end
        end
        default: state_q <= SQ_STEADY;
      endcase
    end
  end

  pwrseq_clkdec u_clkdec (
    .state       (state_q),
    .mode        (mode_q),
    .core_clk_en (core_clk_en),
    .clkgen_en   (clkgen_en),
    .pwr_lvl     (pwr_lvl)
  );

  assign ready    = (state_q == SQ_STEADY);
  assign cur_mode = mode_q;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int LAT_IDLE = 180,
  parameter int LAT_DEEP = 36000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       wake,
  input logic       core_clk_en,
  input logic       clkgen_en,
  input logic       ready,
  input logic [1:0] cur_mode,
  input logic [1:0] pwr_lvl
);
  localparam int LAT_MAX = (LAT_IDLE > LAT_DEEP) ? LAT_IDLE : LAT_DEEP;
  localparam int LIM     = 2 * LAT_MAX;

  int unsigned low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= 0;
    else if (ready)  low_cnt <= 0;
    else             low_cnt <= low_cnt + 1;
  end

  AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cur_mode == 2'b00) |-> (core_clk_en && clkgen_en)); // R2
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cur_mode == 2'b01) |-> (!core_clk_en && clkgen_en)); // R2
  AST_DEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cur_mode[1]) |-> (!core_clk_en && !clkgen_en)); // R2
  AST_ENTRY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid && cur_mode == 2'b00 && req_mode != 2'b00) |=> !ready); // R3
  AST_GATED_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> (cur_mode != 2'b00)); // R4
  AST_EXIT_CLKGEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cur_mode != 2'b00 && wake) |=> (!ready && clkgen_en && !core_clk_en)); // R5
  AST_RUN_WAKE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cur_mode == 2'b00 && wake && !req_valid) |=> (ready && cur_mode == 2'b00)); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req_valid && !wake) |=> (ready && $stable(cur_mode))); // R8
  AST_PWR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_lvl + cur_mode) == 2'd3); // R9
  AST_NO_HANG: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LIM); // R6
endmodule

bind pwr_sequencer pwrseq_chk #(.LAT_IDLE(LAT_IDLE), .LAT_DEEP(LAT_DEEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .wake(wake), .core_clk_en(core_clk_en), .clkgen_en(clkgen_en),
  .ready(ready), .cur_mode(cur_mode), .pwr_lvl(pwr_lvl)
);

// File: tb/pwr_sequencer_test.sv
`timescale 1ns/1ps
module pwr_sequencer_test;
  localparam int LI = 6;
  localparam int LD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic       wake = 1'b0;
  logic       core_clk_en, clkgen_en, ready;
  logic [1:0] cur_mode, pwr_lvl;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwr_sequencer #(.LAT_IDLE(LI), .LAT_DEEP(LD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wake(wake), .core_clk_en(core_clk_en), .clkgen_en(clkgen_en),
    .ready(ready), .cur_mode(cur_mode), .pwr_lvl(pwr_lvl)
  );

  // Scoreboard: expected end mode and ready-low length of each move.
  int exp_mode_q[$];
  int exp_len_q[$];

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_move(input int mode, input int len);
    exp_mode_q.push_back(mode);
    exp_len_q.push_back(len);
  endtask

  // Monitor: measures each low run of ready and compares it when ready returns.
  int  low_len = 0;
  logic was_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) begin
        low_len++;
        was_low = 1'b1;
      end else if (was_low) begin
        was_low = 1'b0;
        if (exp_mode_q.size() == 0) begin
          check("R7 unexpected move", 1, 0);
        end else begin
          int em, el;
          em = exp_mode_q.pop_front();
          el = exp_len_q.pop_front();
          check("R3/R5/R6 move length", low_len, el);
          check("R3/R5 end mode", int'(cur_mode), em);
          check("R2 core_clk_en", int'(core_clk_en), (em == 0) ? 1 : 0);
          check("R2 clkgen_en", int'(clkgen_en), (em <= 1) ? 1 : 0);
          check("R9 pwr_lvl", int'(pwr_lvl), 3 - em);
        end
        low_len = 0;
      end
    end
  end

  task automatic send_req(input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!ready);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(ready), 1);
    check("R1 cur_mode", int'(cur_mode), 0);
    check("R1 core_clk_en", int'(core_clk_en), 1);
    check("R1 clkgen_en", int'(clkgen_en), 1);
    check("R1 pwr_lvl", int'(pwr_lvl), 3);

    // R3 enter IDLE, R4 clocks during entry
    expect_move(1, LI);
    send_req(2'b01);
    check("R4 entry mode", int'(cur_mode), 0);
    check("R4 entry core_clk_en", int'(core_clk_en), 1);
    wait_ready();

    // R5 wake from IDLE
    expect_move(0, LI);
    pulse_wake();
    wait_ready();

    // R3 enter DROWSY; R7 a request during entry is ignored
    expect_move(2, LD);
    send_req(2'b10);
    send_req(2'b11);
    wait_ready();

    // R8 low-to-low request ignored
    send_req(2'b01);
    @(negedge clk);
    check("R8 low-to-low ready", int'(ready), 1);
    check("R8 low-to-low mode", int'(cur_mode), 2);
    // R8 same-mode request ignored
    send_req(2'b10);
    check("R8 same mode ready", int'(ready), 1);

    // R5 RUN request from DROWSY: clkgen restarts at once, core stays gated
    expect_move(0, LD);
    send_req(2'b00);
    check("R5 exit clkgen_en", int'(clkgen_en), 1);
    check("R5 exit core_clk_en", int'(core_clk_en), 0);
    wait_ready();

    // R6 wake during SLEEP entry is held
    expect_move(0, 2 * LD);
    send_req(2'b11);
    repeat (4) @(negedge clk);
    pulse_wake();
    repeat (LD - 4) @(negedge clk);
    check("R6 exit shows SLEEP", int'(cur_mode), 3);
    check("R6 ready still low", int'(ready), 0);
    wait_ready();

    // R8 wake in RUN and RUN request in RUN ignored
    pulse_wake();
    check("R8 wake in RUN", int'(ready), 1);
    send_req(2'b00);
    check("R8 RUN in RUN", int'(ready), 1);
    check("R8 RUN in RUN mode", int'(cur_mode), 0);

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", exp_mode_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule